// File: doc/BRIEF.md
# Miss Fill Buffer with Flush Cancellation

This block tracks cache-line misses from the first-level data cache while they are outstanding at the next memory level. Two load ports present misses, and each miss is keyed by its line-aligned physical address. A miss whose line is already outstanding and still live joins the existing entry. Any other miss takes the lowest free entry, and that entry is then requested from memory over a valid/ready channel that carries the entry index. Memory answers with the entry index and the line data, in any order. In the same cycle, the data is written toward the cache and forwarded to the pipeline bypass on one lane per waiting requester, each lane tagged with that requester's load uop ID.

A pipeline flush does not reclaim entries. It marks every occupied entry as cancelled. A cancelled entry still issues its request and still writes its line into the cache. It never forwards data or a completion, and it stays occupied until its response arrives. When no entry is free, a new miss is refused, and each refusal adds one to a running event count.

Load-port rules: `ld_ready[p]` is a same-cycle verdict and is only high while `ld_valid[p]` is high. A refused request is dropped, so the load buffer must replay it. Memory-request rules: once `mem_req_valid` is high, the index and line stay fixed until `mem_req_ready` is sampled high. The response channel and the bypass lanes have no back-pressure.

Top module: `miss_fill_buffer`

## Requirements
- R1: After reset, no entry is occupied, `full_events` is 0, and `mem_req_valid`, `fill_valid` and every `byp_valid` lane are low.
- R2: A miss that allocates takes the lowest-index free entry. `mem_req_valid` presents the lowest-index occupied entry that has not yet been requested, with its index and line, and holds both stable until `mem_req_ready` is high.
- R3: A miss to the line of an occupied, non-cancelled entry is accepted without allocating, as long as that entry has fewer than WAITERS requesters. A further miss to the same line is refused and is not counted in `full_events`.
- R4: A response forwards `mem_rsp_data` in the same cycle on bypass lane w for each requester w recorded in the entry, with lane 0 being the first requester. It drives `fill_valid` with the entry's line, and it frees the entry.
- R5: A flush marks every occupied entry cancelled, including entries allocated in the flush cycle. A response for a cancelled entry, or a response that arrives in a flush cycle, raises no bypass lane but still drives `fill_valid`.
- R6: A cancelled entry stays occupied until its response arrives, and it is never a merge target.
- R7: A miss that finds no free entry and no mergeable entry is refused, and `full_events` increases by one for each port refused this way in a cycle.
- R8: When both ports allocate in one cycle, port 0 takes the lower entry. With exactly one free entry, port 0 is accepted and port 1 is refused as full.
- R9: When both ports present the same line in one cycle, port 1 is refused and not counted.
- R10: An entry whose response arrives in a cycle can be neither a merge target nor a free entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Pipeline flush; cancels all occupied entries |
| ld_valid | input | 2 | Miss request valid, one bit per load port |
| ld_line | input | 2 x AW | Line-aligned physical address per port |
| ld_uop | input | 2 x UW | Load uop ID per port |
| ld_ready | output | 2 | Request accepted this cycle |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_idx | output | IW | Entry index of the request |
| mem_req_line | output | AW | Line address of the request |
| mem_rsp_valid | input | 1 | Fill data returning |
| mem_rsp_idx | input | IW | Entry the data belongs to |
| mem_rsp_data | input | DW | Line data |
| byp_valid | output | WAITERS | Bypass lane valid |
| byp_uop | output | WAITERS x UW | Uop ID tag per lane |
| byp_data | output | DW | Forwarded data |
| fill_valid | output | 1 | Write line into cache |
| fill_line | output | AW | Line address for the cache write |
| fill_data | output | DW | Line data for the cache write |
| full_events | output | CW | Count of full-buffer refusals |

## Verification
On every cycle, the assertions check that a stalled memory request holds steady, that responses only name entries that are occupied and already requested, and that cancelled or flush-cycle responses stay silent on the bypass. They also check that a flush leaves no live entry behind, that entries only vanish on their own response, that a live line is never held twice, that the refusal count moves only on refusals, and that port 0 wins when both ports allocate. Only the bench's scenarios can show the rest: the exact entry chosen, the order of memory requests, the per-lane uop tags, the refusal verdicts at zero, one and two free entries, and the reuse of an entry only after its fill.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  localparam int LD_PORTS = 2;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_MERGE,
    ACT_ALLOC,
    ACT_FULL,
    ACT_BUSY
  } act_e;
endpackage

// File: rtl/mfb_first_set.sv
module mfb_first_set #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mfb_cam.sv
module mfb_cam #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         live,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         match,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = live[i] && (tags[i] == key);
  end

  mfb_first_set #(.N(N), .IW(IW)) u_pick (
    .vec  (match),
    .found(hit),
    .idx  (idx)
  );
endmodule

// File: rtl/miss_fill_buffer.sv
module miss_fill_buffer
  import mfb_pkg::*;
#(
  parameter int NUM_ENTRIES = 10,
  parameter int WAITERS     = 2,
  parameter int AW          = 12,
  parameter int UW          = 6,
  parameter int DW          = 32,
  parameter int CW          = 16,
  localparam int IW  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WIW = (WAITERS > 1) ? $clog2(WAITERS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [LD_PORTS-1:0]              ld_valid,
  input  logic [LD_PORTS-1:0][AW-1:0]      ld_line,
  input  logic [LD_PORTS-1:0][UW-1:0]      ld_uop,
  output logic [LD_PORTS-1:0]              ld_ready,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic [IW-1:0]                    mem_req_idx,
  output logic [AW-1:0]                    mem_req_line,
  input  logic                             mem_rsp_valid,
  input  logic [IW-1:0]                    mem_rsp_idx,
  input  logic [DW-1:0]                    mem_rsp_data,
  output logic [WAITERS-1:0]               byp_valid,
  output logic [WAITERS-1:0][UW-1:0]       byp_uop,
  output logic [DW-1:0]                    byp_data,
  output logic                             fill_valid,
  output logic [AW-1:0]                    fill_line,
  output logic [DW-1:0]                    fill_data,
  output logic [CW-1:0]                    full_events
);
  localparam int N = NUM_ENTRIES;

  // Entry state
  logic [N-1:0]                        e_valid, e_cancel, e_issued;
  logic [N-1:0][AW-1:0]                e_addr;
  logic [N-1:0][WAITERS-1:0]           e_wv;
  logic [N-1:0][WAITERS-1:0][UW-1:0]   e_wuop;
  logic [N-1:0]                        n_valid, n_cancel, n_issued;
  logic [N-1:0][AW-1:0]                n_addr;
  logic [N-1:0][WAITERS-1:0]           n_wv;
  logic [N-1:0][WAITERS-1:0][UW-1:0]   n_wuop;

  logic [N-1:0] rsp_vec, live, free_v, free_rest;
  assign rsp_vec   = mem_rsp_valid ? (N'(1) << mem_rsp_idx) : '0;
  assign live      = e_valid & ~e_cancel & ~rsp_vec;
  assign free_v    = ~e_valid;
  assign free_rest = free_v & (free_v - N'(1));

  logic          ff0, ff1;
  logic [IW-1:0] fi0, fi1;
  mfb_first_set #(.N(N), .IW(IW)) u_free0 (.vec(free_v),    .found(ff0), .idx(fi0));
  mfb_first_set #(.N(N), .IW(IW)) u_free1 (.vec(free_rest), .found(ff1), .idx(fi1));

  // Per-port lookup and merge-slot search
  logic [LD_PORTS-1:0][N-1:0]   cam_match;
  logic [LD_PORTS-1:0]          cam_hit, slot_ok;
  logic [LD_PORTS-1:0][IW-1:0]  cam_idx;
  logic [LD_PORTS-1:0][WIW-1:0] slot;

  for (genvar p = 0; p < LD_PORTS; p++) begin : g_port
    logic [WAITERS-1:0] open_slots;
    assign open_slots = ~e_wv[cam_idx[p]];
    mfb_cam #(.N(N), .AW(AW), .IW(IW)) u_cam (
      .live (live),
      .tags (e_addr),
      .key  (ld_line[p]),
      .match(cam_match[p]),
      .hit  (cam_hit[p]),
      .idx  (cam_idx[p])
    );
    mfb_first_set #(.N(WAITERS), .IW(WIW)) u_slot (
      .vec  (open_slots),
      .found(slot_ok[p]),
      .idx  (slot[p])
    );
  end

  // Port verdicts: port 0 first, port 1 sees what port 0 took
  act_e [LD_PORTS-1:0]         act;
  logic [LD_PORTS-1:0][IW-1:0] tgt;
  logic                        same_line;
  assign same_line = ld_valid[0] && (ld_line[0] == ld_line[1]);

  always_comb begin
    act[0] = ACT_IDLE;
    tgt[0] = cam_idx[0];
    if (ld_valid[0]) begin
      if (cam_hit[0])  act[0] = slot_ok[0] ? ACT_MERGE : ACT_BUSY;
      else if (ff0)    begin act[0] = ACT_ALLOC; tgt[0] = fi0; end
      else             act[0] = ACT_FULL;
    end
    act[1] = ACT_IDLE;
    tgt[1] = cam_idx[1];
    if (ld_valid[1]) begin
      if (same_line)        act[1] = ACT_BUSY;
      else if (cam_hit[1])  act[1] = slot_ok[1] ? ACT_MERGE : ACT_BUSY;
      else if (act[0] == ACT_ALLOC) begin
        if (ff1) begin act[1] = ACT_ALLOC; tgt[1] = fi1; end
        else     act[1] = ACT_FULL;
      end else if (ff0) begin act[1] = ACT_ALLOC; tgt[1] = fi0; end
      else act[1] = ACT_FULL;
    end
  end

  for (genvar p = 0; p < LD_PORTS; p++) begin : g_rdy
    assign ld_ready[p] = (act[p] == ACT_MERGE) || (act[p] == ACT_ALLOC);
  end

  // Memory request: lowest unrequested entry, locked while stalled
  logic          pend_found, lock_q;
  logic [IW-1:0] pend_idx, lock_idx_q;
  mfb_first_set #(.N(N), .IW(IW)) u_issue (
    .vec(e_valid & ~e_issued), .found(pend_found), .idx(pend_idx)
  );
  assign mem_req_valid = lock_q || pend_found;
  assign mem_req_idx   = lock_q ? lock_idx_q : pend_idx;
  assign mem_req_line  = e_addr[mem_req_idx];

  // Response side
  for (genvar w = 0; w < WAITERS; w++) begin : g_lane
    assign byp_valid[w] = mem_rsp_valid && !flush && !e_cancel[mem_rsp_idx]
                          && e_wv[mem_rsp_idx][w];
    assign byp_uop[w]   = e_wuop[mem_rsp_idx][w];
  end
  assign byp_data   = mem_rsp_data;
  assign fill_valid = mem_rsp_valid;
  assign fill_line  = e_addr[mem_rsp_idx];
  assign fill_data  = mem_rsp_data;

  always_comb begin
    n_valid  = e_valid;
    n_cancel = e_cancel;
    n_issued = e_issued;
    n_addr   = e_addr;
    n_wv     = e_wv;
    n_wuop   = e_wuop;
    if (mem_rsp_valid) begin
      n_valid[mem_rsp_idx]  = 1'b0;
      n_cancel[mem_rsp_idx] = 1'b0;
      n_issued[mem_rsp_idx] = 1'b0;
      n_wv[mem_rsp_idx]     = '0;
    end
    if (flush) n_cancel = n_cancel | n_valid;
    if (mem_req_valid && mem_req_ready) n_issued[mem_req_idx] = 1'b1;
    for (int p = 0; p < LD_PORTS; p++) begin
      if (act[p] == ACT_ALLOC) begin
        n_valid[tgt[p]]     = 1'b1;
        n_cancel[tgt[p]]    = flush;
        n_issued[tgt[p]]    = 1'b0;
        n_addr[tgt[p]]      = ld_line[p];
        n_wv[tgt[p]]        = WAITERS'(1);
        n_wuop[tgt[p]][0]   = ld_uop[p];
      end else if (act[p] == ACT_MERGE) begin
        n_wv[tgt[p]][slot[p]]   = 1'b1;
        n_wuop[tgt[p]][slot[p]] = ld_uop[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid     <= '0;
      e_cancel    <= '0;
      e_issued    <= '0;
      e_addr      <= '0;
      e_wv        <= '0;
      e_wuop      <= '0;
      lock_q      <= 1'b0;
      lock_idx_q  <= '0;
      full_events <= '0;
    end else begin
      e_valid     <= n_valid;
      e_cancel    <= n_cancel;
      e_issued    <= n_issued;
      e_addr      <= n_addr;
      e_wv        <= n_wv;
      e_wuop      <= n_wuop;
      lock_q      <= mem_req_valid && !mem_req_ready;
      lock_idx_q  <= mem_req_idx;
      full_events <= full_events + CW'(act[0] == ACT_FULL) + CW'(act[1] == ACT_FULL);
    end
  end

  // Checks beside the logic
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_idx)
                                        && $stable(mem_req_line));
  p_rsp_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> e_valid[mem_rsp_idx] && e_issued[mem_rsp_idx]);
  p_cancel_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && (flush || e_cancel[mem_rsp_idx]) |-> byp_valid == '0);
  p_flush_cancels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (e_valid & ~e_cancel) == '0);
  p_no_early_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid != '0) |=> (($past(e_valid) & ~$past(rsp_vec)) & ~e_valid) == '0);
  p_unique_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cam_match[0]));
  p_count_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid & ~ld_ready) == '0 |=> $stable(full_events));
  p_port0_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid == 2'b11 && !cam_hit[0] && !cam_hit[1] && !same_line && ld_ready[1]
      |-> ld_ready[0]);
endmodule

// File: tb/miss_fill_buffer_tb.sv
module miss_fill_buffer_tb;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush;
  logic [1:0]       ld_valid;
  logic [1:0][11:0] ld_line;
  logic [1:0][5:0]  ld_uop;
  logic [1:0]       ld_ready;
  logic             mem_req_valid, mem_req_ready;
  logic [3:0]       mem_req_idx;
  logic [11:0]      mem_req_line;
  logic             mem_rsp_valid;
  logic [3:0]       mem_rsp_idx;
  logic [31:0]      mem_rsp_data;
  logic [1:0]       byp_valid;
  logic [1:0][5:0]  byp_uop;
  logic [31:0]      byp_data;
  logic             fill_valid;
  logic [11:0]      fill_line;
  logic [31:0]      fill_data;
  logic [15:0]      full_events;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  miss_fill_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_uop(ld_uop), .ld_ready(ld_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_idx(mem_req_idx), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_idx(mem_rsp_idx), .mem_rsp_data(mem_rsp_data),
    .byp_valid(byp_valid), .byp_uop(byp_uop), .byp_data(byp_data),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .full_events(full_events)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 1'b0; ld_valid = '0; ld_line = '0; ld_uop = '0;
    mem_rsp_valid = 1'b0; mem_rsp_idx = '0; mem_rsp_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; idle(); mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ld(input int p, input logic [11:0] line, input logic [5:0] uop);
    ld_valid[p] = 1'b1; ld_line[p] = line; ld_uop[p] = uop;
  endtask

  task automatic rsp(input logic [3:0] idx, input logic [31:0] data);
    mem_rsp_valid = 1'b1; mem_rsp_idx = idx; mem_rsp_data = data;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 count", full_events, 0);
    chk("R1 req", mem_req_valid, 0);
    chk("R1 byp", byp_valid, 0);
    chk("R1 fill", fill_valid, 0);

    // R2: allocate entry 0, request held while memory stalls
    @(negedge clk); ld(0, 12'h0A1, 6'd5); #1;
    chk("R2 accept", ld_ready[0], 1);
    @(negedge clk); idle(); #1;
    chk("R2 req valid", mem_req_valid, 1);
    chk("R2 req idx", mem_req_idx, 0);
    chk("R2 req line", mem_req_line, 12'h0A1);
    @(negedge clk); #1;
    chk("R2 stall hold", {mem_req_valid, mem_req_idx}, {1'b1, 4'd0});

    // R3: merge then slot exhaustion
    @(negedge clk); ld(0, 12'h0A1, 6'd7); mem_req_ready = 1'b1; #1;
    chk("R3 merge accept", ld_ready[0], 1);
    @(negedge clk); idle(); #1;
    chk("R3 no new entry", mem_req_valid, 0);
    @(negedge clk); ld(0, 12'h0A1, 6'd9); #1;
    chk("R3 slots exhausted", ld_ready[0], 0);
    @(negedge clk); idle(); #1;
    chk("R3 not counted", full_events, 0);

    // R4: response forwards on both lanes and frees entry 0
    @(negedge clk); rsp(4'd0, 32'hCAFE0001); #1;
    chk("R4 lanes", byp_valid, 2'b11);
    chk("R4 uop lane0", byp_uop[0], 5);
    chk("R4 uop lane1", byp_uop[1], 7);
    chk("R4 data", byp_data, 32'hCAFE0001);
    chk("R4 fill", {fill_valid, fill_line}, {1'b1, 12'h0A1});
    @(negedge clk); idle(); ld(0, 12'h0A1, 6'd11); #1;
    chk("R4 realloc accept", ld_ready[0], 1);
    @(negedge clk); idle(); #1;
    chk("R4 freed entry reused", {mem_req_valid, mem_req_idx}, {1'b1, 4'd0});

    // R8: two ports, port 0 takes lower entry
    @(negedge clk); ld(0, 12'h0B2, 6'd1); ld(1, 12'h0C3, 6'd2); #1;
    chk("R8 both accept", ld_ready, 2'b11);
    @(negedge clk); idle(); #1;
    chk("R8 port0 lower", {mem_req_idx, mem_req_line}, {4'd1, 12'h0B2});
    @(negedge clk); #1;
    chk("R8 port1 next", {mem_req_idx, mem_req_line}, {4'd2, 12'h0C3});

    // R9: same line on both ports
    @(negedge clk); ld(0, 12'h0D4, 6'd3); ld(1, 12'h0D4, 6'd4); #1;
    chk("R9 verdicts", ld_ready, 2'b01);
    @(negedge clk); idle(); #1;
    chk("R9 not counted", full_events, 0);

    // R5/R6/R10: flush, then response for cancelled entry 1 with a miss to its line
    @(negedge clk); flush = 1'b1;
    @(negedge clk); idle(); rsp(4'd1, 32'h1111); ld(0, 12'h0B2, 6'd6); #1;
    chk("R5 cancelled silent", byp_valid, 0);
    chk("R5 cancelled fill", {fill_valid, fill_line}, {1'b1, 12'h0B2});
    chk("R10 accept", ld_ready[0], 1);
    @(negedge clk); idle(); #1;
    chk("R10 R6 new entry", {mem_req_valid, mem_req_idx, mem_req_line}, {1'b1, 4'd4, 12'h0B2});
    @(negedge clk); flush = 1'b1; rsp(4'd4, 32'h2222); #1;
    chk("R5 flush same cycle", byp_valid, 0);
    chk("R5 flush fill", fill_valid, 1);
    @(negedge clk); idle();

    // R7/R8 sweep over zero, one and two free entries
    for (int k = 0; k < 3; k++) begin
      do_reset();
      for (int i = 0; i < 10 - k; i++) begin
        @(negedge clk); idle(); ld(0, 12'h100 + 12'(i), 6'(i));
      end
      @(negedge clk); idle(); ld(0, 12'h200, 6'd50); ld(1, 12'h201, 6'd51); #1;
      chk("R8 sweep port0", ld_ready[0], (k >= 1) ? 1 : 0);
      chk("R8 sweep port1", ld_ready[1], (k >= 2) ? 1 : 0);
      @(negedge clk); idle(); #1;
      chk("R7 sweep count", full_events, 2 - ((k < 2) ? k : 2));
      if (k == 0) begin
        @(negedge clk); ld(0, 12'h100, 6'd40); ld(1, 12'h202, 6'd41); #1;
        chk("R7 merge while full", ld_ready, 2'b01);
        @(negedge clk); idle(); #1;
        chk("R7 count after merge", full_events, 3);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); idle(); ld(0, 12'h300, 6'd42); #1;
        chk("R6 still occupied", ld_ready[0], 0);
        @(negedge clk); idle(); #1;
        chk("R6 counted", full_events, 4);
        @(negedge clk); rsp(4'd3, 32'h3333); ld(0, 12'h301, 6'd43); #1;
        chk("R10 not free yet", ld_ready[0], 0);
        chk("R5 sweep silent", byp_valid, 0);
        chk("R5 sweep fill", {fill_valid, fill_line}, {1'b1, 12'h103});
        @(negedge clk); idle(); ld(0, 12'h302, 6'd44); #1;
        chk("R6 freed after fill", ld_ready[0], 1);
        @(negedge clk); idle(); #1;
        chk("R2 reuse idx", {mem_req_valid, mem_req_idx, mem_req_line}, {1'b1, 4'd3, 12'h302});
        chk("R7 final count", full_events, 5);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule